// File: doc/BRIEF.md
# Storage Host Interrupt Status Controller

This block gathers single-cycle event pulses from a storage card host and keeps each one in a sticky raw status bit. The sources include command completion, response and data errors, timeouts, FIFO service requests, card insertion or removal, and interrupts raised by the card itself. Software clears a bit by writing a 1 to its position. A per-bit mask and a global enable reduce the raw bits to one active-high, level-sensitive interrupt line.

Two of the inputs are compound events. In normal operation, a response timeout also marks the command as finished, and a data read timeout also marks the data transfer as finished. When the boot-mode control bit is set, the two timeout status bits take on new meanings. One reports that the boot acknowledge pattern was received. The other reports that boot data has begun to arrive. In this mode each of those bits is set on its own, with no companion bit.

A word-addressed register port gives read and write access to control, mask, masked status and raw status. Reads are combinational. Writes take effect at the next clock edge.

Top module: `sdhost_irq_ctrl`

## Requirements
- R1: A pulse on `evt_i[n]` sets raw status bit n (word address 3) at the next clock edge. The bit then stays 1 until software clears it, whatever the event inputs do afterwards.
- R2: A write to address 3 clears every raw bit whose write-data bit is 1. Raw bits whose write-data bit is 0 keep their value.
- R3: If an event sets a raw bit in the same cycle as a write that clears that bit, the bit is 1 after the edge.
- R4: With boot mode off, `rsp_to_i` sets raw bits 8 and 2, and `rd_to_i` sets raw bits 9 and 3. With boot mode off, `boot_ack_i` and `boot_data_i` have no effect.
- R5: With boot mode on, `boot_ack_i` sets only raw bit 8 and `boot_data_i` sets only raw bit 9. With boot mode on, `rsp_to_i` and `rd_to_i` have no effect. Bits 8 and 9 still clear through R2.
- R6: `irq_o` is registered. In each cycle it equals the value at the previous edge of: control bit 0 AND (at least one raw bit whose mask bit is 1). An event therefore raises `irq_o` two edges after its pulse is sampled.
- R7: While reset is held, control, mask and raw status all read 0 and `irq_o` is 0.
- R8: Address 2 reads raw AND mask. It is read-only: a write to address 2 changes no register.
- R9: Address 0 is control, with bit 0 as the global interrupt enable and bit 1 as boot mode. Address 1 is the mask, with bit n enabling raw bit n. Bits above the used fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 17 | One-cycle event pulses, bit n sets raw bit n |
| rsp_to_i | input | 1 | Response timeout pulse (normal mode) |
| rd_to_i | input | 1 | Data read timeout pulse (normal mode) |
| boot_ack_i | input | 1 | Boot acknowledge received pulse (boot mode) |
| boot_data_i | input | 1 | Boot data started pulse (boot mode) |
| bus_addr_i | input | 2 | Register word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
A raw bit that is lost, or that sets itself, shows up on the next read of address 3 or address 2. If that bit is unmasked while the enable is on, `irq_o` goes wrong one edge later. A compound event routed wrongly for the current mode leaves a missing or extra companion bit that can be seen in the very next cycle. A fault in the clear or priority logic shows as a difference between read data and a cycle-accurate bench model. The bench compares read data and `irq_o` against that model on every clock, so any divergence is caught within one cycle.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_MASK  = 2'd1,
      SEL_MSTAT = 2'd2,
      SEL_RAW   = 2'd3
   } reg_sel_e;

   localparam int CTRL_EN_POS   = 0;
   localparam int CTRL_BOOT_POS = 1;
endpackage

// File: rtl/sdirq_evt_route.sv
module sdirq_evt_route #(
   parameter int NUM_SRC  = 17,
   parameter int RTO_BIT  = 8,
   parameter int CD_BIT   = 2,
   parameter int DRTO_BIT = 9,
   parameter int DTO_BIT  = 3
) (
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               rsp_to_i,
   input  logic               rd_to_i,
   input  logic               boot_ack_i,
   input  logic               boot_data_i,
   input  logic               boot_mode_i,
   output logic [NUM_SRC-1:0] set_o
);
   always_comb begin
      set_o = evt_i;
      if (boot_mode_i) begin
         if (boot_ack_i)  set_o[RTO_BIT]  = 1'b1;
         if (boot_data_i) set_o[DRTO_BIT] = 1'b1;
      end else begin
         if (rsp_to_i) begin
            set_o[RTO_BIT] = 1'b1;
            set_o[CD_BIT]  = 1'b1;
         end
         if (rd_to_i) begin
            set_o[DRTO_BIT] = 1'b1;
            set_o[DTO_BIT]  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sdirq_status.sv
module sdirq_status #(
   parameter int NUM_SRC = 17
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] raw_o
);
   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         raw_o[b] <= 1'b0;
         else if (set_i[b])  raw_o[b] <= 1'b1;
         else if (clr_i[b])  raw_o[b] <= 1'b0;
      end
   end

   // R1, R2: a bit may only fall when a clear was requested for it
   p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(raw_o) & ~$past(clr_i) & ~raw_o) == '0));

   // R3: any set request is visible after the edge, clear or not
   p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((raw_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/sdirq_irq_out.sv
module sdirq_irq_out #(
   parameter int NUM_SRC = 17,
   parameter bit REG_IRQ = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] raw_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic               en_i,
   output logic [NUM_SRC-1:0] mstat_o,
   output logic               irq_o
);
   logic hit;
   assign mstat_o = raw_i & mask_i;
   assign hit     = en_i && (|mstat_o);

   if (REG_IRQ) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= hit;
      end
      assign irq_o = irq_q;

      // R6: the line can only be high if the enable was on one edge before
      p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> $past(en_i));
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_o = hit;
   end
endmodule

// File: rtl/sdhost_irq_ctrl.sv
module sdhost_irq_ctrl #(
   parameter int NUM_SRC  = 17,
   parameter int DATA_W   = 32,
   parameter int RTO_BIT  = 8,
   parameter int CD_BIT   = 2,
   parameter int DRTO_BIT = 9,
   parameter int DTO_BIT  = 3,
   parameter bit REG_IRQ  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               rsp_to_i,
   input  logic               rd_to_i,
   input  logic               boot_ack_i,
   input  logic               boot_data_i,
   input  logic [1:0]         bus_addr_i,
   input  logic               bus_wr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               irq_o
);
   import sdirq_pkg::*;

   localparam int CTRL_W = CTRL_BOOT_POS + 1;

   if (NUM_SRC > DATA_W) begin : g_chk_w
      $error("NUM_SRC must fit in DATA_W");
   end
   if (CTRL_W > DATA_W) begin : g_chk_c
      $error("control field wider than DATA_W");
   end
   if (RTO_BIT >= NUM_SRC || CD_BIT >= NUM_SRC ||
       DRTO_BIT >= NUM_SRC || DTO_BIT >= NUM_SRC) begin : g_chk_b
      $error("paired status bit outside NUM_SRC");
   end
   if (RTO_BIT == CD_BIT || DRTO_BIT == DTO_BIT || RTO_BIT == DRTO_BIT) begin : g_chk_d
      $error("paired status bits must be distinct");
   end

   if (NUM_SRC < DATA_W) begin : g_pad
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:NUM_SRC];
   end

   reg_sel_e          sel;
   logic              en_q, boot_q;
   logic [NUM_SRC-1:0] mask_q, set_v, clr_v, raw_v, mstat_v;

   assign sel   = reg_sel_e'(bus_addr_i);
   assign clr_v = (bus_wr_i && sel == SEL_RAW) ? bus_wdata_i[NUM_SRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         boot_q <= 1'b0;
         mask_q <= '0;
      end else if (bus_wr_i) begin
         if (sel == SEL_CTRL) begin
            en_q   <= bus_wdata_i[CTRL_EN_POS];
            boot_q <= bus_wdata_i[CTRL_BOOT_POS];
         end
         if (sel == SEL_MASK) mask_q <= bus_wdata_i[NUM_SRC-1:0];
      end
   end

   sdirq_evt_route #(
      .NUM_SRC(NUM_SRC), .RTO_BIT(RTO_BIT), .CD_BIT(CD_BIT),
      .DRTO_BIT(DRTO_BIT), .DTO_BIT(DTO_BIT)
   ) u_route (
      .evt_i(evt_i), .rsp_to_i(rsp_to_i), .rd_to_i(rd_to_i),
      .boot_ack_i(boot_ack_i), .boot_data_i(boot_data_i),
      .boot_mode_i(boot_q), .set_o(set_v)
   );

   sdirq_status #(.NUM_SRC(NUM_SRC)) u_status (
      .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .raw_o(raw_v)
   );

   sdirq_irq_out #(.NUM_SRC(NUM_SRC), .REG_IRQ(REG_IRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_v), .mask_i(mask_q), .en_i(en_q),
      .mstat_o(mstat_v), .irq_o(irq_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      unique case (sel)
         SEL_CTRL: begin
            bus_rdata_o[CTRL_EN_POS]   = en_q;
            bus_rdata_o[CTRL_BOOT_POS] = boot_q;
         end
         SEL_MASK:  bus_rdata_o[NUM_SRC-1:0] = mask_q;
         SEL_MSTAT: bus_rdata_o[NUM_SRC-1:0] = mstat_v;
         SEL_RAW:   bus_rdata_o[NUM_SRC-1:0] = raw_v;
      endcase
   end

   // R4: a normal-mode response timeout lands in both of its bits
   p_pair_rto_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_to_i && !boot_q) |=> (raw_v[RTO_BIT] && raw_v[CD_BIT]));

   // R9: control only moves on a write to its address
   p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr_i && bus_addr_i == 2'd0) |=> ($stable(en_q) && $stable(boot_q)));
endmodule

// File: tb/sdhost_irq_ctrl_tb.sv
module sdhost_irq_ctrl_tb;
   localparam int N = 17;
   localparam logic [N-1:0] ALL = '1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0] evt = '0;
   logic rto = 0, drto = 0, back = 0, bdat = 0, wr = 0, irq;
   logic [1:0] addr = '0;
   logic [31:0] wdata = '0, rdata;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   sdhost_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .rsp_to_i(rto), .rd_to_i(drto),
      .boot_ack_i(back), .boot_data_i(bdat), .bus_addr_i(addr), .bus_wr_i(wr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   // behavioural reference
   logic [N-1:0] m_raw, m_mask;
   logic m_en, m_boot, m_irq;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_raw = '0; m_mask = '0; m_en = 0; m_boot = 0; m_irq = 0;
      end else begin
         logic [N-1:0] s, c;
         logic nirq;
         nirq = m_en && ((m_raw & m_mask) != 0);
         s = evt;
         if (m_boot) begin
            if (back) s[8] = 1'b1;
            if (bdat) s[9] = 1'b1;
         end else begin
            if (rto)  begin s[8] = 1'b1; s[2] = 1'b1; end
            if (drto) begin s[9] = 1'b1; s[3] = 1'b1; end
         end
         c = (wr && addr == 2'd3) ? wdata[N-1:0] : '0;
         m_raw = (m_raw & ~c) | s;
         if (wr && addr == 2'd0) begin m_en = wdata[0]; m_boot = wdata[1]; end
         if (wr && addr == 2'd1) m_mask = wdata[N-1:0];
         m_irq = nirq;
      end
   end

   function automatic logic [31:0] m_read(input logic [1:0] a);
      case (a)
         2'd0:    return {30'd0, m_boot, m_en};
         2'd1:    return {15'd0, m_mask};
         2'd2:    return {15'd0, m_raw & m_mask};
         default: return {15'd0, m_raw};
      endcase
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({31'd0, irq}, {31'd0, m_irq}, "R6 irq line");
         case (addr)
            2'd0:    check(rdata, m_read(addr), "R9 ctrl read");
            2'd1:    check(rdata, m_read(addr), "R9 mask read");
            2'd2:    check(rdata, m_read(addr), "R8 masked read");
            default: check(rdata, m_read(addr), "R1 raw read");
         endcase
      end
   end

   task automatic step(input logic [N-1:0] e, input logic r, input logic d,
                       input logic ba, input logic bd, input logic [1:0] a,
                       input logic w, input logic [31:0] wd);
      @(negedge clk); #1;
      evt = e; rto = r; drto = d; back = ba; bdat = bd; addr = a; wr = w; wdata = wd;
   endtask

   task automatic idle(); step('0, 0, 0, 0, 0, 2'd3, 0, 0); endtask
   task automatic wreg(input logic [1:0] a, input logic [31:0] d); step('0, 0, 0, 0, 0, a, 1, d); endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
      step('0, 0, 0, 0, 0, a, 0, 0);
      #1 check(rdata, exp, tag);
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      idle();
      #1 check({31'd0, irq}, {31'd0, exp}, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rd(2'd0, 32'd0, "R7 ctrl in reset");
      rd(2'd1, 32'd0, "R7 mask in reset");
      rd(2'd3, 32'd0, "R7 raw in reset");
      check({31'd0, irq}, 32'd0, "R7 irq in reset");
      @(negedge clk); rst_n = 1'b1;

      // R9 map and unused bits
      wreg(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, 32'd3, "R9 ctrl bits");
      wreg(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, {15'd0, ALL}, "R9 mask width");
      wreg(2'd0, 32'd1);
      idle(); idle();

      // R6 timing
      step(N'(1), 0, 0, 0, 0, 2'd3, 0, 0);
      chk_irq(1'b0, "R6 one edge after event");
      chk_irq(1'b1, "R6 two edges after event");
      wreg(2'd0, 32'd0);
      chk_irq(1'b1, "R6 enable off not yet seen");
      chk_irq(1'b0, "R6 enable off");
      wreg(2'd3, {15'd0, ALL});

      // R1 sticky
      step(N'(1) << 5, 0, 0, 0, 0, 2'd3, 0, 0);
      idle(); idle(); idle();
      rd(2'd3, 32'h20, "R1 sticky bit 5");
      // R2 clear rules
      wreg(2'd3, 32'h0);
      rd(2'd3, 32'h20, "R2 write zero keeps");
      wreg(2'd3, 32'h20);
      rd(2'd3, 32'h0, "R2 write one clears");
      // R3 event beats clear
      step(N'(1) << 7, 0, 0, 0, 0, 2'd3, 1, 32'h80);
      rd(2'd3, 32'h80, "R3 event wins");
      wreg(2'd3, 32'h80);

      // R4 paired events in normal mode; boot pulses ignored
      step('0, 1, 0, 0, 0, 2'd3, 0, 0);
      rd(2'd3, 32'h104, "R4 response timeout pair");
      wreg(2'd3, {15'd0, ALL});
      step('0, 0, 1, 1, 1, 2'd3, 0, 0);
      rd(2'd3, 32'h208, "R4 read timeout pair, boot ignored");
      wreg(2'd3, {15'd0, ALL});

      // R5 boot mode
      wreg(2'd0, 32'd2);
      step('0, 1, 1, 0, 0, 2'd3, 0, 0);
      rd(2'd3, 32'h0, "R5 timeouts ignored in boot");
      step('0, 0, 0, 1, 0, 2'd3, 0, 0);
      rd(2'd3, 32'h100, "R5 boot ack alone");
      step('0, 0, 0, 0, 1, 2'd3, 0, 0);
      rd(2'd3, 32'h300, "R5 boot data alone");
      wreg(2'd3, 32'h100);
      rd(2'd3, 32'h200, "R5 boot bit clears");

      // R8 masked view, read only
      wreg(2'd1, 32'h0000_0300);
      step(N'(1) << 16, 0, 0, 0, 0, 2'd3, 0, 0);
      rd(2'd2, 32'h200, "R8 masked view");
      wreg(2'd2, 32'hFFFF_FFFF);
      rd(2'd1, 32'h300, "R8 write to masked ignored (mask)");
      rd(2'd3, 32'h1_0200, "R8 write to masked ignored (raw)");

      // random traffic checked by the model
      for (int i = 0; i < 3000; i++) begin
         logic [N-1:0] e;
         e = N'($urandom & $urandom & $urandom);
         step(e, ($urandom % 9) == 0, ($urandom % 9) == 0, ($urandom % 9) == 0,
              ($urandom % 9) == 0, 2'($urandom), ($urandom % 6) == 0, $urandom);
      end
      idle(); idle();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule